// File: doc/BRIEF.md
# Dual-Speed CPU Bus-Phase Controller

This block decides, half-cycle by half-cycle, when a processor that shares its bus with a video controller may advance. Each raster line is split into 65 bus cycles, and each cycle has a first half (phi1) and a second half (phi2). In slow mode the processor advances once per cycle, in phi2. In fast mode it advances in both halves, apart from the exceptions below.

Three conditions take cycles away from fast operation. The first is the memory-refresh window at the end of every line, where phi1 is withheld. The second is any I/O access: it always completes on a phi2 edge, so it costs two or three fast half-cycles depending on the half in which it arrives. The third is video DMA on badlines, which applies only in slow mode with the screen enabled. In that case the bus-available line drops three cycles before the video controller takes the bus, and the processor is held for the duration of the fetch.

The raster position is produced by an internal cycle counter that starts at cycle 0, phi1, when reset is released and wraps at the end of each line. The clock-enable output gates the processor core. The bus-available output serves as its ready/halt input. The I/O strobe marks the half-cycle in which an I/O access is actually performed.

Top module: `dual_speed_bus_phaser`

## Requirements
- R1: On the first half-cycle after reset is released, the position is cycle 0, phi1. With fast mode selected and no I/O pending, cpu_ce is 1, bus_avail is 1 and io_strobe is 0.
- R2: A line lasts 130 half-cycles, alternating phi1 and phi2. The cycle count runs from 0 to 64 and returns to 0 after phi2 of cycle 64, so every line repeats the same pattern.
- R3: In slow mode (speed_fast=0), cpu_ce is 0 in every phi1 half. With no halt it is 1 in every phi2 half, giving 65 enables per line.
- R4: In fast mode, cpu_ce is 1 in every half except phi1 of cycles 60 to 64 (the refresh window). This gives 125 enables per line when there is no I/O.
- R5: In fast mode, an I/O access (io_hit=1) that first appears in phi1 gets no enable in that half. The following phi2 carries cpu_ce=1 and io_strobe=1, so the access takes 2 half-cycles.
- R6: In fast mode, an I/O access that first appears in phi2 gets no enable in that half or in the next phi1. The phi2 after those carries cpu_ce=1 and io_strobe=1, so the access takes 3 half-cycles.
- R7: In slow mode, an I/O access presented in phi1 completes with cpu_ce=1 and io_strobe=1 in the following phi2. io_strobe is never 1 in phi1.
- R8: In slow mode, with screen_on=1 and badline=1, bus_avail is 0 from cycle 12 through cycle 54 (86 half-cycles). cpu_ce is 0 in cycles 15 to 54, leaving 25 enables per line.
- R9: During a halt, the three cycles 12 to 14 are a lead-in: bus_avail is already 0, but the phi2 enable is still given so that a write in progress can finish. bus_avail returns to 1 at cycle 55, and the enable returns in phi2 of cycle 55.
- R10: In fast mode a badline has no effect. bus_avail stays 1 and the line still gives 125 enables.
- R11: With screen_on=0, a badline has no effect. In slow mode bus_avail stays 1 and the line gives 65 enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock; one edge per phi1 or phi2 half |
| rst | input | 1 | Synchronous active-high reset |
| speed_fast | input | 1 | 1 selects fast (two enables per cycle), 0 selects slow |
| screen_on | input | 1 | 1 when the video display is enabled |
| badline | input | 1 | 1 when the current raster line is a video DMA line |
| io_hit | input | 1 | Processor address decodes to I/O space; held until io_strobe |
| cpu_ce | output | 1 | Processor clock enable for this half-cycle |
| bus_avail | output | 1 | 0 requests the processor to halt for video DMA |
| io_strobe | output | 1 | I/O access is performed in this half-cycle |

## Verification
The checker watches several rules on every cycle. The counter must wrap after phi2 of the last cycle. phi1 must never enable in slow mode, and never inside the refresh window in fast mode. The strobe may appear only on an enabled phi2 with io_hit present. A missing slow-mode phi2 enable is allowed only while bus_avail is low, and fast mode must never drop bus_avail. The per-line enable totals can only be shown by the bench's scenarios: 125, 65 and 25 for the fast, slow and halted lines. The same holds for the 2- and 3-half-cycle I/O costs that depend on the arrival phase, and for the exact edges of the halt lead-in and release.

// File: rtl/dsbp_pkg.sv
package dsbp_pkg;

    localparam int LINE_CYCLES = 65;
    localparam int CYC_W       = $clog2(LINE_CYCLES);

    typedef enum logic {PH1 = 1'b0, PH2 = 1'b1} phase_e;

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        phase_e           ph;
    } slot_t;

    typedef struct packed {
        logic halt_req;   // bus_avail low
        logic dma_take;   // video owns the bus
        logic refresh;    // fast-mode phi1 withheld
    } window_t;

    function automatic logic in_span(input logic [CYC_W-1:0] c,
                                     input int first, input int len);
        return (int'(c) >= first) && (int'(c) < first + len);
    endfunction

endpackage

// File: rtl/bus_raster_timer.sv
module bus_raster_timer
    import dsbp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_t slot
);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(LINE_CYCLES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot.cyc <= '0;
            slot.ph  <= PH1;
        end else if (slot.ph == PH1) begin
            slot.ph <= PH2;
        end else begin
            slot.ph  <= PH1;
            slot.cyc <= (slot.cyc == LAST_CYC) ? '0 : slot.cyc + 1'b1;
        end
    end
endmodule

// File: rtl/bus_dma_window.sv
module bus_dma_window
    import dsbp_pkg::*;
#(
    parameter int REFRESH_CYCLES = 5,
    parameter int DMA_FIRST      = 15,
    parameter int DMA_CYCLES     = 40,
    parameter int HALT_LEAD      = 3
) (
    input  slot_t   slot,
    input  logic    speed_fast,
    input  logic    screen_on,
    input  logic    badline,
    output window_t win
);
    localparam int REFRESH_FIRST = LINE_CYCLES - REFRESH_CYCLES;
    localparam int HALT_FIRST    = DMA_FIRST - HALT_LEAD;
    localparam int HALT_CYCLES   = DMA_CYCLES + HALT_LEAD;

    logic dma_line;

    always_comb begin
        // Fast mode suppresses the video controller's bus takeover.
        dma_line     = !speed_fast && screen_on && badline;
        win.halt_req = dma_line && in_span(slot.cyc, HALT_FIRST, HALT_CYCLES);
        win.dma_take = dma_line && in_span(slot.cyc, DMA_FIRST, DMA_CYCLES);
        win.refresh  = speed_fast && (slot.ph == PH1)
                       && in_span(slot.cyc, REFRESH_FIRST, REFRESH_CYCLES);
    end
endmodule

// File: rtl/bus_cycle_gate.sv
module bus_cycle_gate
    import dsbp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  slot_t   slot,
    input  window_t win,
    input  logic    speed_fast,
    input  logic    io_hit,
    output logic    cpu_ce,
    output logic    io_strobe
);
    // Set when an I/O access was seen during phi1; lets the next phi2 run it.
    logic io_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            io_armed <= 1'b0;
        end else if (slot.ph == PH1) begin
            io_armed <= speed_fast && io_hit && !win.dma_take;
        end else begin
            io_armed <= 1'b0;
        end
    end

    always_comb begin
        if (win.dma_take) begin
            cpu_ce = 1'b0;
        end else if (slot.ph == PH2) begin
            cpu_ce = speed_fast ? (!io_hit || io_armed) : 1'b1;
        end else begin
            cpu_ce = speed_fast && !win.refresh && !io_hit;
        end
        io_strobe = cpu_ce && io_hit && (slot.ph == PH2);
    end
endmodule

// File: rtl/dual_speed_bus_phaser.sv
module dual_speed_bus_phaser
    import dsbp_pkg::*;
#(
    parameter int REFRESH_CYCLES = 5,
    parameter int DMA_FIRST      = 15,
    parameter int DMA_CYCLES     = 40,
    parameter int HALT_LEAD      = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic speed_fast,
    input  logic screen_on,
    input  logic badline,
    input  logic io_hit,
    output logic cpu_ce,
    output logic bus_avail,
    output logic io_strobe
);
    slot_t   slot;
    window_t win;

    bus_raster_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    bus_dma_window #(
        .REFRESH_CYCLES (REFRESH_CYCLES),
        .DMA_FIRST      (DMA_FIRST),
        .DMA_CYCLES     (DMA_CYCLES),
        .HALT_LEAD      (HALT_LEAD)
    ) u_window (
        .slot       (slot),
        .speed_fast (speed_fast),
        .screen_on  (screen_on),
        .badline    (badline),
        .win        (win)
    );

    bus_cycle_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .slot       (slot),
        .win        (win),
        .speed_fast (speed_fast),
        .io_hit     (io_hit),
        .cpu_ce     (cpu_ce),
        .io_strobe  (io_strobe)
    );

    assign bus_avail = !win.halt_req;
endmodule

// File: rtl/dual_speed_bus_phaser_chk.sv
module dual_speed_bus_phaser_chk
    import dsbp_pkg::*;
#(
    parameter int REFRESH_CYCLES = 5
) (
    input logic  clk,
    input logic  rst,
    input logic  speed_fast,
    input logic  io_hit,
    input logic  cpu_ce,
    input logic  bus_avail,
    input logic  io_strobe,
    input slot_t slot
);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(LINE_CYCLES - 1);
    localparam logic [CYC_W-1:0] REF_CYC  = CYC_W'(LINE_CYCLES - REFRESH_CYCLES);

    // R2
    line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (slot.ph == PH2 && slot.cyc == LAST_CYC) |=> (slot.cyc == '0 && slot.ph == PH1));

    // R3
    slow_phi1_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!speed_fast && slot.ph == PH1) |-> !cpu_ce);

    // R4
    refresh_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (speed_fast && slot.ph == PH1 && slot.cyc >= REF_CYC) |-> !cpu_ce);

    // R5
    strobe_on_phi2_chk: assert property (@(posedge clk) disable iff (rst)
        io_strobe |-> (cpu_ce && io_hit && slot.ph == PH2));

    // R8
    slow_gap_halted_chk: assert property (@(posedge clk) disable iff (rst)
        (!speed_fast && slot.ph == PH2 && !cpu_ce) |-> !bus_avail);

    // R10
    fast_no_halt_chk: assert property (@(posedge clk) disable iff (rst)
        speed_fast |-> bus_avail);
endmodule

bind dual_speed_bus_phaser dual_speed_bus_phaser_chk #(
    .REFRESH_CYCLES (REFRESH_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .speed_fast (speed_fast),
    .io_hit     (io_hit),
    .cpu_ce     (cpu_ce),
    .bus_avail  (bus_avail),
    .io_strobe  (io_strobe),
    .slot       (slot)
);

// File: tb/dual_speed_bus_phaser_tb.sv
`timescale 1ns/1ps
module dual_speed_bus_phaser_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic speed_fast = 1'b1;
    logic screen_on  = 1'b1;
    logic badline    = 1'b0;
    logic io_hit     = 1'b0;
    logic cpu_ce, bus_avail, io_strobe;

    int checks   = 0;
    int failures = 0;
    int h        = 0;   // half-cycle index since reset release
    bit done     = 1'b0;
    logic ce_arr [130];
    logic ba_arr [130];

    always #4 clk = ~clk;

    dual_speed_bus_phaser u_dut (
        .clk        (clk),
        .rst        (rst),
        .speed_fast (speed_fast),
        .screen_on  (screen_on),
        .badline    (badline),
        .io_hit     (io_hit),
        .cpu_ce     (cpu_ce),
        .bus_avail  (bus_avail),
        .io_strobe  (io_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic adv();
        @(negedge clk);
        h++;
    endtask

    // Advance until the current half-cycle sits at position pos within the line.
    task automatic wait_to(input int pos);
        do adv(); while ((h % 130) != pos);
    endtask

    task automatic run_line(input logic f, input logic s, input logic b,
                            output int ce_cnt, output int ba_low);
        wait_to(0);
        speed_fast = f; screen_on = s; badline = b; io_hit = 1'b0;
        ce_cnt = 0; ba_low = 0;
        for (int i = 0; i < 130; i++) begin
            if (i > 0) adv();
            #1;
            ce_arr[i] = cpu_ce;
            ba_arr[i] = bus_avail;
            ce_cnt += int'(cpu_ce);
            ba_low += int'(!bus_avail);
        end
    endtask

    // Present I/O at line position pos, count half-cycles up to and including the strobe.
    task automatic io_cost(input logic f, input int pos, output int cost, output bit phi1_strobe);
        wait_to(pos);
        speed_fast = f; screen_on = 1'b1; badline = 1'b0; io_hit = 1'b1;
        #1;
        cost = 1;
        phi1_strobe = 1'b0;
        while (!io_strobe && cost < 6) begin
            adv(); #1;
            cost++;
        end
        if (io_strobe && (h % 2) == 0) phi1_strobe = 1'b1;
        if (!cpu_ce) cost = 99;
        adv();
        io_hit = 1'b0;
    endtask

    task automatic t_reset();
        check(cpu_ce == 1'b1, "R1 ce", int'(cpu_ce), 1);
        check(bus_avail == 1'b1, "R1 bus_avail", int'(bus_avail), 1);
        check(io_strobe == 1'b0, "R1 strobe", int'(io_strobe), 0);
    endtask

    task automatic t_fast_lines();
        int c1, c2, b;
        run_line(1'b1, 1'b1, 1'b0, c1, b);
        check(c1 == 125, "R4 fast ce per line", c1, 125);
        check(ce_arr[118] == 1'b1 && ce_arr[120] == 1'b0 && ce_arr[128] == 1'b0
              && ce_arr[121] == 1'b1, "R4 refresh edges", int'(ce_arr[120]), 0);
        run_line(1'b1, 1'b1, 1'b0, c2, b);
        check(c2 == c1 && ce_arr[120] == 1'b0 && ce_arr[0] == 1'b1,
              "R2 line repeats", c2, c1);
    endtask

    task automatic t_slow_line();
        int c, b;
        run_line(1'b0, 1'b1, 1'b0, c, b);
        check(c == 65, "R3 slow ce per line", c, 65);
        check(ce_arr[40] == 1'b0 && ce_arr[41] == 1'b1, "R3 phi2 only", int'(ce_arr[40]), 0);
    endtask

    task automatic t_io();
        int cost;
        bit p1;
        io_cost(1'b1, 40, cost, p1);
        check(cost == 2, "R5 phi1 arrival cost", cost, 2);
        io_cost(1'b1, 61, cost, p1);
        check(cost == 3, "R6 phi2 arrival cost", cost, 3);
        io_cost(1'b0, 40, cost, p1);
        check(cost == 2 && !p1, "R7 slow io on phi2", cost, 2);
    endtask

    task automatic t_badline_slow();
        int c, b;
        run_line(1'b0, 1'b1, 1'b1, c, b);
        check(c == 25, "R8 halted ce per line", c, 25);
        check(b == 86, "R8 bus_avail low halves", b, 86);
        check(ba_arr[23] == 1'b1 && ba_arr[24] == 1'b0, "R9 halt lead start",
              int'(ba_arr[24]), 0);
        check(ce_arr[29] == 1'b1 && ce_arr[31] == 1'b0, "R9 lead-in enable",
              int'(ce_arr[29]), 1);
        check(ba_arr[109] == 1'b0 && ba_arr[110] == 1'b1 && ce_arr[109] == 1'b0
              && ce_arr[111] == 1'b1, "R9 release", int'(ce_arr[111]), 1);
    endtask

    task automatic t_badline_fast();
        int c, b;
        run_line(1'b1, 1'b1, 1'b1, c, b);
        check(c == 125, "R10 fast badline ce", c, 125);
        check(b == 0, "R10 fast badline bus_avail", b, 0);
    endtask

    task automatic t_screen_off();
        int c, b;
        run_line(1'b0, 1'b0, 1'b1, c, b);
        check(c == 65, "R11 screen off ce", c, 65);
        check(b == 0, "R11 screen off bus_avail", b, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        h = 0;
        #1;
        t_reset();
        t_fast_lines();
        t_slow_line();
        t_io();
        t_badline_slow();
        t_badline_fast();
        t_screen_off();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R1-run actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule